// File: doc/BRIEF.md
# I2C Register-Pointer Slave with Snapshot Freeze

This block is the bus-facing front end of a 64-byte register space whose first eight locations mirror a running timekeeping counter. It watches the two-wire serial bus through synchronisers and recognises START, repeated START and STOP. It answers one 7-bit device address. It keeps a volatile word-address pointer that sets which register each data byte goes to or comes from. Byte-wide read and write strobes at the pointer give the surrounding logic access to the register storage.

The pointer is loaded by the byte that follows a write-direction address. It steps forward after every byte that is acknowledged, and after 3Fh it returns to 00h. Reads can begin at a newly written pointer, which is a random read through a repeated START. They can also begin wherever the pointer was left, which is a current-address read. A read continues until the master declines a byte.

While a matched transfer has the pointer inside the clock image, the block raises a freeze output. The counter logic must not overwrite that image while freeze is high, so the bus sees a coherent snapshot. Freeze drops on STOP, or as soon as the pointer advances past the image.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After reset, sda_oe is 0, freeze is 0 and reg_addr is 00h. No byte on the bus is acknowledged before a START.
- R2: The slave acknowledges an address byte only when its upper seven bits equal 1101000b; bit 0 is the direction, where 0 means write and 1 means read. For any other address the slave sends no acknowledge and keeps sda_oe at 0 until the next START.
- R3: In a write-direction frame, the first byte after the address is acknowledged, and its low six bits become the pointer.
- R4: Each further byte of a write frame is presented on reg_wdata with a one-cycle reg_we at the current pointer and is acknowledged. The pointer then advances by one.
- R5: A repeated START followed by the read-direction address returns the byte stored at the pointer just written. Data is sent most significant bit first.
- R6: During a read, the pointer advances only when the master acknowledges the byte just sent, and the next byte follows at the new pointer. A not-acknowledge leaves the pointer unchanged, releases SDA and ends the slave's part until a new START.
- R7: A read-direction frame with no pointer write first returns the byte at the pointer left by the last transfer.
- R8: The pointer advances from 3Fh to 00h.
- R9: freeze is 1 while a transfer addressed to this slave is open and the pointer is below 08h. This holds for both read and write frames, including after a wrap into 00h.
- R10: freeze returns to 0 on STOP, and also while the frame stays open once the pointer advances to 08h.
- R11: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 6 | Register address, equal to the pointer |
| reg_wdata | output | 8 | Byte to store at reg_addr |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Byte stored at reg_addr, combinational |
| freeze | output | 1 | Holds the clock image stable |

## Verification
The embedded properties watch, on every cycle, that SDA moves only while SCL is low, that an idle slave never drives the line, that every register write coincides with an acknowledge, and that freeze is down the cycle after a STOP. Other behaviour can only be shown by bus scenarios that a reference model predicts. These are pointer loading and stepping, wrap-around, the retained pointer after a not-acknowledge, current-address reads, and freeze following the pointer into and out of the clock image.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_WORD  = 3'd2,
      ST_WDATA = 3'd3,
      ST_TX    = 3'd4
   } bus_state_e;

   localparam int unsigned BYTE_W  = 8;
   localparam logic [3:0]  CNT_ACK = 4'd8;
   localparam logic [3:0]  CNT_END = 4'd9;
endpackage

// File: rtl/i2c_regptr_linesync.sv
module i2c_regptr_linesync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_hi,
   output logic sda_hi,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_s, sda_s, scl_d, sda_d;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_s <= 1'b1;
               sda_s <= 1'b1;
            end else begin
               scl_s <= scl_i;
               sda_s <= sda_i;
            end
         end
      end else begin : g_chain
         logic [STAGES-1:0] scl_c, sda_c;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_c <= '1;
               sda_c <= '1;
            end else begin
               scl_c <= {scl_c[STAGES-2:0], scl_i};
               sda_c <= {sda_c[STAGES-2:0], sda_i};
            end
         end
         assign scl_s = scl_c[STAGES-1];
         assign sda_s = sda_c[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_hi    = scl_s;
   assign sda_hi    = sda_s;
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_regptr_pointer.sv
module i2c_regptr_pointer #(
   parameter int unsigned AW       = 6,
   parameter int unsigned CLK_SPAN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          inc_i,
   input  logic          sess_set_i,
   input  logic          sess_clr_i,
   output logic [AW-1:0] ptr_o,
   output logic          freeze_o
);
   localparam logic [AW:0] SPAN_W = CLK_SPAN[AW:0];

   logic [AW-1:0] ptr_q;
   logic          sess_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_i) begin
         ptr_q <= load_val_i;
      end else if (inc_i) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sess_q <= 1'b0;
      end else if (sess_clr_i) begin
         sess_q <= 1'b0;
      end else if (sess_set_i) begin
         sess_q <= 1'b1;
      end
   end

   assign ptr_o    = ptr_q;
   assign freeze_o = sess_q & ({1'b0, ptr_q} < SPAN_W);

   AST_FREEZE_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      sess_clr_i |=> !freeze_o); // R10
endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
   import i2c_regptr_pkg::*;
#(
   parameter int unsigned AW          = 6,
   parameter logic [6:0]  DEV_ADDR    = 7'b1101000,
   parameter int unsigned CLK_SPAN    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   output logic [AW-1:0] reg_addr,
   output logic [7:0]    reg_wdata,
   output logic          reg_we,
   input  logic [7:0]    reg_rdata,
   output logic          freeze
);
   generate
      if (AW < 1 || AW > BYTE_W) begin : g_bad_aw
         $error("AW must lie in 1..8");
      end
      if (CLK_SPAN > (1 << AW)) begin : g_bad_span
         $error("CLK_SPAN exceeds the register space");
      end
   endgenerate

   logic scl_hi, sda_hi, scl_rise, scl_fall, start_det, stop_det;

   i2c_regptr_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   bus_state_e    st_q;
   logic [3:0]    cnt_q;
   logic [7:0]    rx_q, tx_q;
   logic          rw_q, nack_q, oe_q, we_q;
   logic          ld_q, inc_q, sess_set_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; cnt_q <= '0; rx_q <= '0; tx_q <= '0;
         rw_q <= 1'b0; nack_q <= 1'b0; oe_q <= 1'b0; we_q <= 1'b0;
         ld_q <= 1'b0; inc_q <= 1'b0; sess_set_q <= 1'b0;
      end else begin
         we_q <= 1'b0; ld_q <= 1'b0; inc_q <= 1'b0; sess_set_q <= 1'b0;
         if (start_det) begin
            st_q <= ST_ADDR; cnt_q <= '0; oe_q <= 1'b0; nack_q <= 1'b0;
         end else if (stop_det) begin
            st_q <= ST_IDLE; oe_q <= 1'b0;
         end else if (st_q != ST_IDLE && scl_rise) begin
            if (cnt_q < CNT_END) cnt_q <= cnt_q + 4'd1;
            if (st_q != ST_TX && cnt_q < CNT_ACK) rx_q <= {rx_q[6:0], sda_hi};
            if (st_q == ST_TX && cnt_q == CNT_ACK) begin
               nack_q <= sda_hi;
               inc_q  <= ~sda_hi;
            end
         end else if (st_q != ST_IDLE && scl_fall) begin
            unique case (st_q)
               ST_ADDR: begin
                  if (cnt_q == CNT_ACK) begin
                     if (rx_q[7:1] == DEV_ADDR) begin
                        oe_q <= 1'b1; rw_q <= rx_q[0]; sess_set_q <= 1'b1;
                     end else begin
                        st_q <= ST_IDLE;
                     end
                  end else if (cnt_q == CNT_END) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        st_q <= ST_TX; tx_q <= reg_rdata; oe_q <= ~reg_rdata[7];
                     end else begin
                        st_q <= ST_WORD; oe_q <= 1'b0;
                     end
                  end
               end
               ST_WORD: begin
                  if (cnt_q == CNT_ACK) begin
                     oe_q <= 1'b1; ld_q <= 1'b1;
                  end else if (cnt_q == CNT_END) begin
                     oe_q <= 1'b0; cnt_q <= '0; st_q <= ST_WDATA;
                  end
               end
               ST_WDATA: begin
                  if (cnt_q == CNT_ACK) begin
                     oe_q <= 1'b1; we_q <= 1'b1;
                  end else if (cnt_q == CNT_END) begin
                     oe_q <= 1'b0; cnt_q <= '0; inc_q <= 1'b1;
                  end
               end
               ST_TX: begin
                  if (cnt_q >= 4'd1 && cnt_q < CNT_ACK) begin
                     tx_q <= {tx_q[6:0], 1'b0}; oe_q <= ~tx_q[6];
                  end else if (cnt_q == CNT_ACK) begin
                     oe_q <= 1'b0;
                  end else if (cnt_q == CNT_END) begin
                     if (nack_q) begin
                        st_q <= ST_IDLE;
                     end else begin
                        cnt_q <= '0; tx_q <= reg_rdata; oe_q <= ~reg_rdata[7];
                     end
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   i2c_regptr_pointer #(.AW(AW), .CLK_SPAN(CLK_SPAN)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load_i(ld_q), .load_val_i(rx_q[AW-1:0]), .inc_i(inc_q),
      .sess_set_i(sess_set_q), .sess_clr_i(stop_det),
      .ptr_o(reg_addr), .freeze_o(freeze));

   assign sda_oe    = oe_q;
   assign reg_we    = we_q;
   assign reg_wdata = rx_q;

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_hi); // R11
   AST_IDLE_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !sda_oe); // R2
   AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> sda_oe); // R4
   AST_NACK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TX && scl_rise && cnt_q == CNT_ACK && sda_hi) |=> !inc_q); // R6
endmodule

// File: tb/i2c_regptr_slave_tb.sv
module i2c_regptr_slave_tb;
   localparam int Q = 8;
   localparam logic [6:0] DEV = 7'b1101000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic scl = 1'b1, m_oe = 1'b0;
   logic s_oe, reg_we, freeze;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   wire sda = ~(m_oe | s_oe);

   logic [7:0] mem [64];
   logic [7:0] exp_mem [64];
   logic [5:0] exp_ptr;
   int checks = 0, fails = 0;
   bit done = 0;

   assign reg_rdata = mem[reg_addr];
   always_ff @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

   i2c_regptr_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(s_oe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata), .freeze(freeze));

   function automatic logic exp_freeze(input logic [5:0] p);
      return p < 6'd8;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_oe = 1'b0; tick(Q); scl = 1'b1; tick(2*Q);
      m_oe = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_oe = 1'b1; tick(Q); scl = 1'b1; tick(2*Q);
      m_oe = 1'b0; tick(2*Q);
   endtask

   task automatic put_bit(input logic b);
      m_oe = ~b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      m_oe = 1'b0; tick(Q); scl = 1'b1; tick(Q); b = sda; tick(Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b); d[i] = b;
      end
      put_bit(~mack);
   endtask

   task automatic do_write(input logic [5:0] a, input int len);
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte({DEV, 1'b0}, ack); check("R2 address ack", ack, 1);
      send_byte({2'b00, a}, ack); check("R3 word ack", ack, 1);
      exp_ptr = a;
      check("R9 freeze after pointer load", freeze, exp_freeze(exp_ptr));
      for (int i = 0; i < len; i++) begin
         d = 8'($urandom);
         send_byte(d, ack); check("R4 data ack", ack, 1);
         exp_mem[exp_ptr] = d;
         exp_ptr = exp_ptr + 6'd1;
         check("R10 freeze tracks pointer", freeze, exp_freeze(exp_ptr));
      end
      bus_stop();
      check("R10 freeze low after STOP", freeze, 0);
      check("R4 pointer after write", reg_addr, exp_ptr);
   endtask

   task automatic read_body(input int len, input string tag);
      logic [7:0] d;
      check("R9 freeze during read", freeze, exp_freeze(exp_ptr));
      for (int i = 0; i < len; i++) begin
         recv_byte(d, i != len - 1);
         check(tag, d, exp_mem[exp_ptr]);
         if (i != len - 1) exp_ptr = exp_ptr + 6'd1;
      end
      check("R6 released after NACK", s_oe, 0);
      check("R6 pointer kept after NACK", reg_addr, exp_ptr);
      bus_stop();
      check("R10 freeze low after STOP", freeze, 0);
   endtask

   task automatic do_rand_read(input logic [5:0] a, input int len);
      logic ack;
      bus_start();
      send_byte({DEV, 1'b0}, ack); check("R2 address ack", ack, 1);
      send_byte({2'b00, a}, ack); check("R3 word ack", ack, 1);
      exp_ptr = a;
      bus_start();
      send_byte({DEV, 1'b1}, ack); check("R5 read address ack", ack, 1);
      read_body(len, "R5 R6 random read data");
   endtask

   task automatic do_cur_read(input int len);
      logic ack;
      bus_start();
      send_byte({DEV, 1'b1}, ack); check("R7 read address ack", ack, 1);
      read_body(len, "R7 current read data");
   endtask

   task automatic do_foreign();
      logic ack;
      bus_start();
      send_byte({7'b1010000, 1'b0}, ack); check("R2 foreign address no ack", ack, 0);
      send_byte(8'h05, ack); check("R2 stays off bus", ack, 0);
      check("R2 no freeze", freeze, 0);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      end
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 64; i++) begin
         mem[i] = 8'(i * 7 + 3);
         exp_mem[i] = 8'(i * 7 + 3);
      end
      exp_ptr = '0;
      tick(5);
      check("R1 reset sda_oe", s_oe, 0);
      check("R1 reset freeze", freeze, 0);
      check("R1 reset pointer", reg_addr, 0);
      rst_n = 1'b1;
      tick(5);
      do_cur_read(2);                  // R7 from reset pointer 00h
      do_foreign();                    // R2
      do_cur_read(1);                  // R7 pointer untouched by foreign frame
      do_write(6'h06, 2);              // R10 freeze drops at 08h
      do_write(6'h3E, 3);              // R8 wrap, R9 freeze returns at 00h
      check("R8 wrapped pointer", reg_addr, 6'h01);
      do_rand_read(6'h3F, 2);          // R8 read wrap
      do_rand_read(6'h02, 4);          // R9 read in clock image
      for (int n = 0; n < 24; n++) begin
         int op = $urandom_range(0, 3);
         logic [5:0] a = 6'($urandom);
         int len = $urandom_range(1, 4);
         case (op)
            0: do_write(a, len);
            1: do_rand_read(a, len);
            2: do_cur_read(len);
            default: do_foreign();
         endcase
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      end
      $finish;
   end
endmodule